// File: doc/BRIEF.md
# Packet-Read PIO Burst Sequencer

This block is the device side of a packet-command read over a 16-bit programmed-I/O data port. The host programs a byte-count limit through two byte-wide registers and issues the packet command. It then writes the six-word command packet and pulls the response data one word per data-register read. A local decoder supplies the total transfer length once the packet has been taken. A local source supplies the data words in order.

The response is cut into bursts. Each burst holds at most half the even-rounded limit in words, and the last burst holds whatever remains. Every burst opens with an interrupt and a data-request status. The transfer closes with a final interrupt and a ready-only status. A status read acknowledges the interrupt.

Top module: `pio_burst_seq`

## Requirements
- R1: After reset the status byte reads 0x40 (ready only), the interrupt is low and no source word is popped. Status bit positions: BSY bit 7, DRDY bit 6, DF bit 5, DRQ bit 3, ERR bit 0. DF and ERR are always 0.
- R2: The limit is a 16-bit value. Its low byte is written at address 4 and its high byte at address 5, from bits 7:0 of the write data. The words in a full burst equal the limit shifted right by one, or one word when that gives zero.
- R3: A write of 0xA0 to address 7 while idle starts a transfer. The status then reads 0xC0 (BSY and DRDY) for PKT_DELAY cycles and then 0x48 (DRQ and DRDY).
- R4: Six writes to data address 0 take the packet. After them the status reads 0xC0 until the length input is valid for a cycle.
- R5: Before each burst the interrupt rises with status 0x48. The number of bursts is ceil(words / burst words). Every burst but the last carries the full burst size.
- R6: Each data-register read (address 0) while DRQ is set returns the current source word and pops exactly one word. The words come in source order.
- R7: After the last word the interrupt rises again and the status reads 0x40.
- R8: A status read (address 7) acknowledges the interrupt. The interrupt is low in the following cycle unless a new one is raised in that cycle.
- R9: A data-register read while DRQ is clear returns 0 and pops no word.
- R10: A command byte other than 0xA0 is ignored and the status stays 0x40. A zero length completes at once with an interrupt and status 0x40. Word count is the byte length rounded up to whole words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe |
| hostAddr | input | 3 | Register address (0 data, 4 limit low, 5 limit high, 7 command/status) |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data, combinational |
| irq | output | 1 | Interrupt request |
| lenValid | input | 1 | Total length valid strobe from the packet decoder |
| lenBytes | input | LEN_W | Total transfer length in bytes |
| srcWord | input | 16 | Current word from the local data source |
| srcPop | output | 1 | Advance the local data source by one word |

## Verification
The hardest cases to reach are a burst edge that falls exactly on the end of data, and an odd limit whose dropped low bit must not leak into the burst size. A host that reads too many or too few words at a boundary reveals either fault. Fixed-seed random limits, odd and even, are paired with lengths that are not multiples of the burst size. Directed runs cover a limit of one, an odd limit with a short last burst, a limit of 0xFFFE and a zero length. The bench reads exactly its own computed burst size and then waits for the next interrupt, so a wrong boundary shows up as a missing interrupt or a word mismatch.

// File: rtl/pio_burst_pkg.sv
package pio_burst_pkg;
  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_LIMLO = 3'd4;
  localparam logic [2:0] ADDR_LIMHI = 3'd5;
  localparam logic [2:0] ADDR_CMD = 3'd7;
  localparam logic [7:0] CMD_PACKET = 8'hA0;
  localparam int PKT_WORDS = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_PKTWAIT, S_PKTRX, S_LENWAIT, S_ARM, S_XFER
  } seqState_t;

  typedef struct packed {
    logic loadLimLo;
    logic loadLimHi;
    logic loadLen;
    logic startBurst;
    logic popWord;
  } seqStrobes_t;
endpackage

// File: rtl/pio_burst_dp.sv
module pio_burst_dp
  import pio_burst_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  input  logic [15:0]      hostWrData,
  input  logic [LEN_W-1:0] lenBytes,
  input  logic             rdStatusSel,
  input  logic             rdDataSel,
  input  logic [7:0]       statusByte,
  input  logic [15:0]      srcWord,
  output logic             remZero,
  output logic             remLast,
  output logic             burstLast,
  output logic [15:0]      hostRdData
);
  localparam int BW = 15;

  logic [15:0]      limitReg;
  logic [LEN_W-1:0] remWords;
  logic [BW-1:0]    burstLeft;
  logic [BW-1:0]    limWords;
  logic [LEN_W:0]   lenRound;
  logic [LEN_W-1:0] limWide;

  assign limWords = (limitReg[15:1] == '0) ? BW'(1) : limitReg[15:1];
  assign limWide  = LEN_W'(limWords);
  assign lenRound = ({1'b0, lenBytes} + (LEN_W+1)'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitReg  <= '0;
      remWords  <= '0;
      burstLeft <= '0;
    end else begin
      if (strobes.loadLimLo) limitReg[7:0]  <= hostWrData[7:0];
      if (strobes.loadLimHi) limitReg[15:8] <= hostWrData[7:0];
      if (strobes.loadLen) begin
        remWords <= lenRound[LEN_W-1:0];
      end else if (strobes.popWord) begin
        remWords <= remWords - LEN_W'(1);
      end
      if (strobes.startBurst) begin
        burstLeft <= (remWords < limWide) ? BW'(remWords) : limWords;
      end else if (strobes.popWord) begin
        burstLeft <= burstLeft - BW'(1);
      end
    end
  end

  assign remZero   = (remWords == '0);
  assign remLast   = (remWords == LEN_W'(1));
  assign burstLast = (burstLeft == BW'(1));

  always_comb begin
    hostRdData = '0;
    if (rdStatusSel)    hostRdData = {8'h00, statusByte};
    else if (rdDataSel) hostRdData = srcWord;
  end
endmodule

// File: rtl/pio_burst_ctrl.sv
module pio_burst_ctrl
  import pio_burst_pkg::*;
#(
  parameter int PKT_DELAY = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [2:0]  hostAddr,
  input  logic [15:0] hostWrData,
  input  logic        lenValid,
  input  logic        remZero,
  input  logic        remLast,
  input  logic        burstLast,
  output seqStrobes_t strobes,
  output logic        rdStatusSel,
  output logic        rdDataSel,
  output logic [7:0]  statusByte,
  output logic        irq
);
  localparam int DLY_W = (PKT_DELAY > 1) ? $clog2(PKT_DELAY) : 1;
  localparam int PKT_W = $clog2(PKT_WORDS);

  seqState_t        state;
  logic [DLY_W-1:0] dlyCnt;
  logic [PKT_W-1:0] pktCnt;
  logic             wrData, wrCmd, drq;

  assign drq         = (state == S_XFER);
  assign wrData      = hostWrEn && (hostAddr == ADDR_DATA);
  assign wrCmd       = hostWrEn && (hostAddr == ADDR_CMD);
  assign rdStatusSel = hostRdEn && (hostAddr == ADDR_CMD);
  assign rdDataSel   = hostRdEn && (hostAddr == ADDR_DATA) && drq;

  always_comb begin
    strobes            = '0;
    strobes.loadLimLo  = hostWrEn && (hostAddr == ADDR_LIMLO);
    strobes.loadLimHi  = hostWrEn && (hostAddr == ADDR_LIMHI);
    strobes.loadLen    = (state == S_LENWAIT) && lenValid;
    strobes.startBurst = (state == S_ARM) && !remZero;
    strobes.popWord    = rdDataSel;
  end

  always_comb begin
    unique case (state)
      S_IDLE:                       statusByte = 8'h40;
      S_PKTRX, S_XFER:              statusByte = 8'h48;
      S_PKTWAIT, S_LENWAIT, S_ARM:  statusByte = 8'hC0;
      default:                      statusByte = 8'h40;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      dlyCnt <= '0;
      pktCnt <= '0;
      irq    <= 1'b0;
    end else begin
      if (rdStatusSel) irq <= 1'b0;
      unique case (state)
        S_IDLE: if (wrCmd && hostWrData[7:0] == CMD_PACKET) begin
          state  <= S_PKTWAIT;
          dlyCnt <= '0;
          irq    <= 1'b0;
        end
        S_PKTWAIT: begin
          dlyCnt <= dlyCnt + DLY_W'(1);
          if (dlyCnt == DLY_W'(PKT_DELAY - 1)) begin
            state  <= S_PKTRX;
            pktCnt <= '0;
          end
        end
        S_PKTRX: if (wrData) begin
          pktCnt <= pktCnt + PKT_W'(1);
          if (pktCnt == PKT_W'(PKT_WORDS - 1)) state <= S_LENWAIT;
        end
        S_LENWAIT: if (lenValid) state <= S_ARM;
        S_ARM: begin
          irq   <= 1'b1;
          state <= remZero ? S_IDLE : S_XFER;
        end
        S_XFER: if (rdDataSel && burstLast) begin
          if (remLast) begin
            state <= S_IDLE;
            irq   <= 1'b1;
          end else begin
            state <= S_ARM;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_burst_seq.sv
module pio_burst_seq
  import pio_burst_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int PKT_DELAY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic [2:0]       hostAddr,
  input  logic [15:0]      hostWrData,
  output logic [15:0]      hostRdData,
  output logic             irq,
  input  logic             lenValid,
  input  logic [LEN_W-1:0] lenBytes,
  input  logic [15:0]      srcWord,
  output logic             srcPop
);
  seqStrobes_t strobes;
  logic        remZero, remLast, burstLast;
  logic        rdStatusSel, rdDataSel;
  logic [7:0]  statusByte;

  pio_burst_ctrl #(.PKT_DELAY(PKT_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .lenValid(lenValid),
    .remZero(remZero), .remLast(remLast), .burstLast(burstLast),
    .strobes(strobes), .rdStatusSel(rdStatusSel), .rdDataSel(rdDataSel),
    .statusByte(statusByte), .irq(irq)
  );

  pio_burst_dp #(.LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostWrData(hostWrData),
    .lenBytes(lenBytes), .rdStatusSel(rdStatusSel), .rdDataSel(rdDataSel),
    .statusByte(statusByte), .srcWord(srcWord), .remZero(remZero),
    .remLast(remLast), .burstLast(burstLast), .hostRdData(hostRdData)
  );

  assign srcPop = strobes.popWord;
endmodule

// File: rtl/pio_burst_seq_chk.sv
module pio_burst_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostRdEn,
  input logic [2:0] hostAddr,
  input logic       irq,
  input logic       srcPop,
  input logic [7:0] statusByte
);
  logic rdStatus;
  assign rdStatus = hostRdEn && (hostAddr == 3'd7);

  // R9: a word leaves the source only on a data read while DRQ is shown
  a_r9_pop_needs_drq: assert property (@(posedge clk) disable iff (!rstN)
    srcPop |-> (statusByte[3] && hostRdEn && hostAddr == 3'd0));

  // R3: busy and data request never shown together
  a_r3_bsy_drq_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[3]));

  // R1: fault and error bits stay clear
  a_r1_err_df_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] == 1'b0) && (statusByte[0] == 1'b0));

  // R8: status read during a burst acknowledges the interrupt
  a_r8_status_ack: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && statusByte == 8'h48) |=> !irq);

  // R5: a new interrupt comes with ready and without busy
  a_r5_irq_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (statusByte[6] && !statusByte[7]));
endmodule

bind pio_burst_seq pio_burst_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
  .irq(irq), .srcPop(srcPop), .statusByte(statusByte)
);

// File: tb/pio_burst_seq_tb_top.sv
`timescale 1ns/1ps
module pio_burst_seq_tb_top;
  localparam int LEN_W = 20;
  localparam int PKT_DELAY = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0, lenValid = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [15:0] hostWrData = '0, hostRdData, srcWord;
  logic [LEN_W-1:0] lenBytes = '0;
  logic irq, srcPop;
  int unsigned srcIdx = 0;
  int unsigned expIdx = 0;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pio_burst_seq #(.LEN_W(LEN_W), .PKT_DELAY(PKT_DELAY)) dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .irq(irq), .lenValid(lenValid), .lenBytes(lenBytes),
    .srcWord(srcWord), .srcPop(srcPop)
  );

  function automatic logic [15:0] patt(int unsigned i);
    logic [31:0] p;
    p = i * 32'h9E37 + 32'h1357;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  assign srcWord = patt(srcIdx);
  always @(posedge clk) if (rstN && srcPop) srcIdx <= srcIdx + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(posedge clk); @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    hostRdEn = 1'b1; hostAddr = a;
    #1 d = hostRdData;
    @(posedge clk); @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic waitIrq(input string tag);
    int n = 0;
    while (!irq && n < 64) begin @(negedge clk); n++; end
    chk(irq === 1'b1, tag, irq, 1);
  endtask

  task automatic runXfer(input int limit, input int len);
    logic [15:0] v;
    int words, lw, done, bursts, expB, nb, n;
    wr(3'd4, 16'(limit & 8'hFF));
    wr(3'd5, 16'((limit >> 8) & 8'hFF));
    wr(3'd7, 16'h00A0);
    rd(3'd7, v); chk(v == 16'h00C0, "R3 busy after command", v, 16'hC0);
    n = 0;
    while (v[7] && n < 40) begin rd(3'd7, v); n++; end
    chk(v == 16'h0048, "R3 packet request", v, 16'h48);
    for (int i = 0; i < 6; i++) wr(3'd0, 16'(i));
    rd(3'd7, v); chk(v == 16'h00C0, "R4 busy waiting for length", v, 16'hC0);
    lenValid = 1'b1; lenBytes = LEN_W'(len);
    @(posedge clk); @(negedge clk);
    lenValid = 1'b0;
    words = (len + 1) / 2;
    lw = limit / 2; if (lw == 0) lw = 1;
    expB = (words + lw - 1) / lw;
    done = 0; bursts = 0;
    while (done < words) begin
      waitIrq("R5 burst interrupt");
      rd(3'd7, v); chk(v == 16'h0048, "R5 burst status", v, 16'h48);
      chk(irq == 1'b0, "R8 status read acks interrupt", irq, 0);
      nb = (words - done < lw) ? words - done : lw;
      for (int k = 0; k < nb; k++) begin
        rd(3'd0, v);
        chk(v == patt(expIdx), "R6 data word order", v, patt(expIdx));
        expIdx++;
      end
      done += nb; bursts++;
    end
    waitIrq(words == 0 ? "R10 zero length interrupt" : "R7 final interrupt");
    rd(3'd7, v); chk(v == 16'h0040, "R7 final status", v, 16'h40);
    chk(irq == 1'b0, "R8 ack of final interrupt", irq, 0);
    chk(bursts == expB, "R5 burst count", bursts, expB);
    chk(srcIdx == expIdx, "R6 pops match reads", srcIdx, expIdx);
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int unsigned seed;
    seed = $urandom(32'd20231);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(3'd7, v); chk(v == 16'h0040, "R1 reset status", v, 16'h40);
    chk(irq == 1'b0, "R1 reset interrupt", irq, 0);
    chk(srcIdx == 0, "R1 no pop at reset", srcIdx, 0);
    // R9: data read when idle
    rd(3'd0, v); chk(v == 16'h0000, "R9 idle data read", v, 0);
    @(negedge clk);
    chk(srcIdx == 0, "R9 idle read pops nothing", srcIdx, 0);
    // R10: foreign command ignored
    wr(3'd7, 16'h00EC);
    repeat (8) @(negedge clk);
    rd(3'd7, v); chk(v == 16'h0040, "R10 other command ignored", v, 16'h40);
    chk(irq == 1'b0, "R10 no interrupt on other command", irq, 0);
    // directed cases
    runXfer(20, 60);      // R2 even limit, 3 full bursts
    runXfer(7, 20);       // R2 odd limit: 3 words, short last burst
    runXfer(1, 6);        // R2 limit below 2 gives one-word bursts
    runXfer(16'hFFFE, 40);// single burst
    runXfer(10, 9);       // R10 odd byte length rounds up
    runXfer(8, 0);        // R10 zero length
    rd(3'd0, v); chk(v == 16'h0000, "R9 data read after completion", v, 0);
    @(negedge clk);
    chk(srcIdx == expIdx, "R9 no pop after completion", srcIdx, expIdx);
    // random mix
    for (int t = 0; t < 10; t++) begin
      int lim, len;
      lim = 2 + int'($urandom_range(0, 300));
      len = 2 + int'($urandom_range(0, 1200));
      runXfer(lim, len);
    end
    runXfer(5121, 20480); // R2 odd large limit, four bursts
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule